// File: doc/BRIEF.md
# SDRAM Read Command Sequencer

This block sits on the controller side of an SDRAM interface and turns one read request (bank, row, column) into the command sequence the memory expects. It opens the row with an activate command, holds no-operation commands for a programmable row-to-column delay, and then issues the read with auto-precharge so the bank closes behind the burst. After the programmed CAS latency it samples the DQ bus once per clock for the programmed burst length. Each sampled word is presented on a valid/data stream, and a done pulse follows.

CAS latency, burst length and the row-to-column delay arrive on configuration inputs that mirror the memory's mode register. They are captured when a request is accepted. The block handles one request at a time. While it is busy, further requests are dropped.

Top module: `sdram_rd_seq`

## Requirements
- R1: While reset is asserted and immediately after it, `sd_cmd_o` is NOP and `busy_o`, `rd_valid_o` and `done_o` are low.
- R2: A request seen while idle is accepted. In the next cycle `sd_cmd_o` is ACT, with the bank on `sd_ba_o`, the row on `sd_addr_o`, and `busy_o` high.
- R3: The READ command appears exactly T cycles after the ACT cycle, where T is `cfg_trcd_i` and a value of 0 is treated as 1. Only NOP is driven between the two commands.
- R4: The READ command carries the same bank as the ACT. `sd_addr_o` holds the column zero-extended in its low bits, with address bit 10 set to request auto-precharge.
- R5: `cfg_cl_i` = 0 selects CAS latency 2 and 1 selects 3. The first word is the DQ value sampled at the end of the cycle CL cycles after the READ cycle. It is presented on `rd_data_o` with `rd_valid_o` high in the following cycle.
- R6: `cfg_bl_i` codes 0, 1, 2, 3 select burst lengths 1, 2, 4, 8. That many words are delivered on consecutive cycles, each being DQ sampled one cycle after the previous word.
- R7: `busy_o` stays high from the cycle after acceptance and falls in the cycle that presents the last word.
- R8: A request arriving while `busy_o` is high is ignored. No extra ACT is issued and the running burst is unchanged.
- R9: `done_o` pulses for exactly one cycle, in the cycle after the last word is presented.
- R10: Configuration inputs are sampled only at acceptance. Changing them during a burst does not alter its timing or length.
- R11: Commands are encoded on {CS#, RAS#, CAS#, WE#} as ACT = 4'b0011, READ = 4'b0101 and NOP = 4'b0111. No other code is ever driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request strobe |
| req_bank_i | input | BA_W | Request bank |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request start column |
| cfg_trcd_i | input | TRCD_W | Row-to-column delay in cycles (0 treated as 1) |
| cfg_cl_i | input | 1 | CAS latency select: 0 means 2, 1 means 3 |
| cfg_bl_i | input | 2 | Burst length code: 1 << code words |
| sd_cmd_o | output | 4 | {CS#, RAS#, CAS#, WE#} command |
| sd_ba_o | output | BA_W | Bank address |
| sd_addr_o | output | ROW_W | Row or column address |
| sd_dq_i | input | DQ_W | Read data from memory |
| busy_o | output | 1 | Request in progress |
| rd_valid_o | output | 1 | Captured word valid |
| rd_data_o | output | DQ_W | Captured word |
| done_o | output | 1 | Pulse after the final word |

## Verification
The hardest case to reach from the ports is a request that arrives mid-burst while the configuration inputs change at the same moment. A sloppy design would restart the sequence or pick up the new latency or length. The stimulus raises a second request with different bank, row, latency, length and delay two cycles after acceptance, and holds it for two busy cycles. The bench drives DQ with a value unique to each clock cycle. Any word sampled one cycle early or late, or under the wrong latency, therefore shows up as a data mismatch rather than passing silently.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;
  typedef enum logic [3:0] {
    CMD_ACT  = 4'b0011,
    CMD_READ = 4'b0101,
    CMD_NOP  = 4'b0111
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TRCD,
    ST_CAS,
    ST_BURST
  } seq_st_e;

  function automatic logic [3:0] burst_words(input logic [1:0] code);
    return 4'(1) << code;
  endfunction
endpackage

// File: rtl/sdrd_ctrl.sv
module sdrd_ctrl
  import sdrd_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int TRCD_W = 3,
  parameter int AP_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BA_W-1:0]   req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [TRCD_W-1:0] cfg_trcd_i,
  input  logic              cfg_cl_i,
  input  logic [1:0]        cfg_bl_i,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic              busy_o,
  output logic              cap_en_o,
  output logic              cap_last_o,
  output logic [3:0]        burst_len_o
);
  localparam int CNT_W = (TRCD_W > 3) ? TRCD_W : 3;
  localparam int GAP_W = TRCD_W + 1;

  seq_st_e            state_q;
  sd_cmd_e            cmd_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BA_W-1:0]    ba_q;
  logic [ROW_W-1:0]   addr_q;
  logic [COL_W-1:0]   col_q;
  logic               cl3_q;
  logic [1:0]         bl_q;
  logic [TRCD_W-1:0]  trcd_eff_q;
  logic [ROW_W-1:0]   rd_addr;

  always_comb begin
    rd_addr         = ROW_W'(col_q);
    rd_addr[AP_BIT] = 1'b1;  // auto-precharge closes the bank
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cmd_q      <= CMD_NOP;
      cnt_q      <= '0;
      ba_q       <= '0;
      addr_q     <= '0;
      col_q      <= '0;
      cl3_q      <= 1'b0;
      bl_q       <= '0;
      trcd_eff_q <= TRCD_W'(1);
    end else begin
      cmd_q <= CMD_NOP;
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            state_q    <= ST_TRCD;
            cmd_q      <= CMD_ACT;
            ba_q       <= req_bank_i;
            addr_q     <= req_row_i;
            col_q      <= req_col_i;
            cl3_q      <= cfg_cl_i;
            bl_q       <= cfg_bl_i;
            trcd_eff_q <= (cfg_trcd_i == '0) ? TRCD_W'(1) : cfg_trcd_i;
            cnt_q      <= (cfg_trcd_i == '0) ? '0 : CNT_W'(cfg_trcd_i - 1'b1);
          end
        end
        ST_TRCD: begin
          if (cnt_q == '0) begin
            cmd_q   <= CMD_READ;
            addr_q  <= rd_addr;
            state_q <= ST_CAS;
            cnt_q   <= cl3_q ? CNT_W'(2) : CNT_W'(1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_CAS: begin
          if (cnt_q == '0) begin
            state_q <= ST_BURST;
            cnt_q   <= CNT_W'(burst_words(bl_q) - 4'd1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  assign cmd_o       = cmd_q;
  assign ba_o        = ba_q;
  assign addr_o      = addr_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign cap_en_o    = (state_q == ST_BURST);
  assign cap_last_o  = (state_q == ST_BURST) && (cnt_q == '0);
  assign burst_len_o = burst_words(bl_q);

  // independent cycle count since the last ACT
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                gap_q <= '0;
    else if (cmd_q == CMD_ACT)  gap_q <= GAP_W'(1);
    else if (gap_q != '1)       gap_q <= gap_q + 1'b1;
  end

  a_r3_trcd_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_READ) |-> (gap_q == {1'b0, trcd_eff_q}));

  a_r2_act_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i) |=> (cmd_o == 4'b0011 && busy_o));

  a_r8_no_act_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (cmd_o != 4'b0011));

  a_r11_cmd_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 4'b0011) || (cmd_o == 4'b0101) || (cmd_o == 4'b0111));
endmodule

// File: rtl/sdrd_capture.sv
module sdrd_capture #(
  parameter int DQ_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DQ_W-1:0] dq_i,
  input  logic            cap_en_i,
  input  logic            cap_last_i,
  input  logic [3:0]      burst_len_i,
  output logic            rd_valid_o,
  output logic [DQ_W-1:0] rd_data_o,
  output logic            done_o
);
  logic            valid_q, last_q, done_q;
  logic [DQ_W-1:0] data_q;
  logic [3:0]      len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      len_q   <= '0;
    end else begin
      valid_q <= cap_en_i;
      last_q  <= cap_en_i && cap_last_i;
      done_q  <= last_q;
      if (cap_en_i) begin
        data_q <= dq_i;
        len_q  <= burst_len_i;
      end
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;
  assign done_o     = done_q;

  logic [3:0] vcnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vcnt_q <= '0;
    else if (done_q) vcnt_q <= '0;
    else if (valid_q) vcnt_q <= vcnt_q + 1'b1;
  end

  a_r6_burst_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (vcnt_q == len_q));

  a_r9_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(rd_valid_o) && !rd_valid_o));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq #(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DQ_W   = 16,
  parameter int TRCD_W = 3,
  parameter int AP_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BA_W-1:0]   req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [TRCD_W-1:0] cfg_trcd_i,
  input  logic              cfg_cl_i,
  input  logic [1:0]        cfg_bl_i,
  output logic [3:0]        sd_cmd_o,
  output logic [BA_W-1:0]   sd_ba_o,
  output logic [ROW_W-1:0]  sd_addr_o,
  input  logic [DQ_W-1:0]   sd_dq_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic [DQ_W-1:0]   rd_data_o,
  output logic              done_o
);
  logic       cap_en, cap_last;
  logic [3:0] burst_len;

  sdrd_ctrl #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .TRCD_W(TRCD_W), .AP_BIT(AP_BIT)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_bank_i(req_bank_i),
    .req_row_i(req_row_i), .req_col_i(req_col_i),
    .cfg_trcd_i(cfg_trcd_i), .cfg_cl_i(cfg_cl_i), .cfg_bl_i(cfg_bl_i),
    .cmd_o(sd_cmd_o), .ba_o(sd_ba_o), .addr_o(sd_addr_o),
    .busy_o(busy_o), .cap_en_o(cap_en), .cap_last_o(cap_last),
    .burst_len_o(burst_len)
  );

  sdrd_capture #(.DQ_W(DQ_W)) u_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .dq_i(sd_dq_i),
    .cap_en_i(cap_en), .cap_last_i(cap_last), .burst_len_i(burst_len),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .done_o(done_o)
  );

  a_r7_valid_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o) && !$past(rd_valid_o)) |-> !rd_valid_o);
endmodule

// File: tb/sdram_rd_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_rd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_bank;
  logic [12:0] req_row;
  logic [9:0]  req_col;
  logic [2:0]  cfg_trcd;
  logic        cfg_cl;
  logic [1:0]  cfg_bl;
  logic [3:0]  sd_cmd;
  logic [1:0]  sd_ba;
  logic [12:0] sd_addr;
  logic [15:0] sd_dq;
  logic        busy, rd_valid, done;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] pat(input int k);
    return 16'((k * 40503) ^ 23130);
  endfunction

  always @(negedge clk) sd_dq <= pat(cyc);

  sdram_rd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .cfg_trcd_i(cfg_trcd), .cfg_cl_i(cfg_cl), .cfg_bl_i(cfg_bl),
    .sd_cmd_o(sd_cmd), .sd_ba_o(sd_ba), .sd_addr_o(sd_addr), .sd_dq_i(sd_dq),
    .busy_o(busy), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_row = '0; req_col = '0;
    cfg_trcd = 3'd2; cfg_cl = 1'b0; cfg_bl = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sd_cmd == 4'b0111, "R1 cmd NOP in reset", int'(sd_cmd), 7);
    chk(!busy && !rd_valid && !done, "R1 flags low in reset", int'({busy, rd_valid, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sd_cmd == 4'b0111 && !busy, "R1 idle after reset", int'({busy, sd_cmd}), 7);
  endtask

  task automatic run_burst(input int bank, input int row, input int col, input int trcd,
                           input int cl, input int bl, input bit noise, input string nm);
    int a, teff, blen, cln, c;
    int act_n = 0, act_c = -100, act_ba = 0, act_ad = 0;
    int rd_n = 0, rd_c = -100, rd_ba = 0, rd_ad = 0;
    int bad_cmd = 0, nop_bad = 0, vn = 0, first_v = -100, v_err = 0, d_err = 0;
    int done_n = 0, done_c = -100, bfall = -100;
    teff = (trcd == 0) ? 1 : trcd;
    blen = 1 << bl;
    cln  = cl ? 3 : 2;
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'(bank); req_row = 13'(row); req_col = 10'(col);
    cfg_trcd = 3'(trcd); cfg_cl = cl[0]; cfg_bl = 2'(bl);
    a = cyc;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      c = cyc;
      if (i == 0) req_valid = 1'b0;
      if (noise && i == 1) begin
        req_valid = 1'b1; req_bank = ~req_bank; req_row = req_row ^ 13'h155;
        cfg_cl = ~cfg_cl; cfg_bl = cfg_bl ^ 2'd1; cfg_trcd = 3'd7;
      end
      if (noise && i == 3) req_valid = 1'b0;
      case (sd_cmd)
        4'b0011: begin act_n++; act_c = c; act_ba = int'(sd_ba); act_ad = int'(sd_addr); end
        4'b0101: begin rd_n++; rd_c = c; rd_ba = int'(sd_ba); rd_ad = int'(sd_addr); end
        4'b0111: ;
        default: bad_cmd++;
      endcase
      if (act_n == 1 && rd_n == 0 && c > act_c && sd_cmd != 4'b0111) nop_bad++;
      if (rd_valid) begin
        if (vn == 0) first_v = c;
        if (c != rd_c + cln + vn + 1) v_err++;
        if (rd_data != pat(rd_c + cln + vn)) begin
          d_err++;
          $display("FAIL R6 %s word %0d actual=%0h expected=%0h", nm, vn, rd_data, pat(rd_c + cln + vn));
        end
        vn++;
      end
      if (done) begin done_n++; done_c = c; end
      if (bfall < 0 && !busy) bfall = c;
    end
    cfg_trcd = 3'd2; cfg_cl = 1'b0; cfg_bl = 2'd2;
    chk(act_n == 1 && act_c == a + 1, {"R2 ACT cycle ", nm}, act_c - a, 1);
    chk(act_ba == bank && act_ad == row, {"R2 ACT bank/row ", nm}, act_ad, row);
    chk(rd_n == 1 && rd_c - act_c == teff, {"R3 ACT-READ gap ", nm}, rd_c - act_c, teff);
    chk(nop_bad == 0, {"R3 NOP during wait ", nm}, nop_bad, 0);
    chk(rd_ba == bank && rd_ad == (col | 32'h400), {"R4 READ address ", nm}, rd_ad, col | 32'h400);
    chk(first_v == rd_c + cln + 1, {"R5 first word cycle ", nm}, first_v - rd_c, cln + 1);
    chk(vn == blen && v_err == 0 && d_err == 0, {"R6 burst words ", nm}, vn, blen);
    chk(bfall == rd_c + cln + blen, {"R7 busy fall ", nm}, bfall - rd_c, cln + blen);
    chk(done_n == 1 && done_c == bfall + 1, {"R9 done pulse ", nm}, done_n, 1);
    chk(bad_cmd == 0, {"R11 legal command codes ", nm}, bad_cmd, 0);
    if (noise) begin
      chk(act_n == 1, {"R8 busy request ignored ", nm}, act_n, 1);
      chk(vn == blen && first_v == rd_c + cln + 1, {"R10 cfg held from accept ", nm}, vn, blen);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    run_burst(1, 13'h0abc, 10'h123, 2, 0, 2, 1'b0, "cl2 bl4");
    run_burst(3, 13'h1fff, 10'h3ff, 3, 1, 3, 1'b0, "cl3 bl8");
    run_burst(0, 13'h0001, 10'h000, 1, 0, 0, 1'b0, "bl1 trcd1");
    run_burst(2, 13'h0555, 10'h2aa, 0, 1, 1, 1'b0, "bl2 trcd0");
    run_burst(1, 13'h0777, 10'h0f0, 7, 0, 0, 1'b0, "trcd7");
    run_burst(2, 13'h0321, 10'h111, 1, 0, 1, 1'b1, "busy noise");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule